// File: doc/BRIEF.md
# Bit-Serial Distributed Arithmetic FIR Filter

This block is a K-tap finite impulse response filter that needs no multiplier. It keeps the K most recent input samples in a tap line. Once a sample is accepted, the block takes one bit position from every stored sample in each clock. Those K bits form the address of a table. The table holds every possible sum of a subset of the coefficients, and it is filled at elaboration from a coefficient parameter array.

Each table output goes into an accumulator that halves its running value before every add. The bits that fall off the bottom are kept, so nothing is lost. Bit positions are applied from the least significant bit upward. The final slice holds the sign bits, and its table output is subtracted instead of added, because the samples are two's complement. One exact, full-precision result comes out for every B-bit input sample, B clocks after the sample was accepted.

A producer offers a sample with `in_valid`. The block takes it only when `in_ready` is high, which happens only between computations. The consumer takes `result` during the single cycle in which `result_valid` is high.

Top module: `da_fir_core`

## Requirements
- R1: `in_ready` is high only while no computation runs. A sample is taken only in a cycle where `in_valid` and `in_ready` are both high, and `in_ready` is low in the cycle after that.
- R2: `result_valid` goes high for exactly one cycle, exactly DW clock edges after the edge that took the sample. `in_ready` is high in that same cycle, so a new sample can be taken on the next edge.
- R3: `result` equals the exact two's complement sum over k of COEF[k]·x[n−k]. Here x[n] is the newest sample and COEF[0] weights it. The sum is DW+CW+P bits wide, with no rounding or truncation.
- R4: Reset clears the tap history to zero, leaves `result_valid` low and drives `in_ready` high. The first results after reset therefore see zero for every older sample.
- R5: `in_valid` asserted while a computation runs is ignored. The tap line does not move, later results match a model that never saw those samples, and `result` holds its value except in cycles where `result_valid` is high.
- R6: Extreme operands give exact results with no overflow. These are samples of −2^(DW−1) and 2^(DW−1)−1 combined with coefficients of −2^(CW−1) and 2^(CW−1)−1.
- R7: Table entry a is the sum of COEF[k] over every k where bit k of a is 1, so entry 0 is zero. A unit impulse (sample value 1, only bit 0 set) therefore brings out COEF[0], COEF[1], … on successive results.
- R8: The sign-bit slice is weighted by −2^(DW−1). A sample of −1 (all bits set) gives −COEF[k] on the matching results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample offered |
| in_data | input | DW | Two's complement input sample |
| in_ready | output | 1 | Block is idle and will take a sample |
| result_valid | output | 1 | One-cycle strobe, `result` is new |
| result | output | DW+CW+P | Exact filtered output, two's complement |

## Verification
The bench feeds impulses, negative impulses, random streams and extreme values, and compares each result against a direct multiply-accumulate model.

Each kind of internal fault shows up at the ports within one result period of DW cycles:
- A wrong table entry changes the impulse response. It shows on the first result whose tap history uses that coefficient subset.
- A slice sign or order error corrupts the very next result.
- A tap line that moves while busy, or a history left over from before reset, leaves every following result off until K clean samples have passed.
- A wrong bit counter moves the `result_valid` strobe away from the edge the bench samples.

// File: rtl/da_fir_pkg.sv
package da_fir_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } da_state_e;

    // growth bits p such that 2^(p-1) < n <= 2^p
    function automatic int unsigned grow_bits(input int unsigned n);
        int unsigned p;
        p = 0;
        while ((32'd1 << p) < n) p++;
        return p;
    endfunction

endpackage

// File: rtl/da_tap_line.sv
module da_tap_line #(
    parameter int NTAP = 8,
    parameter int DW   = 16,
    localparam int IW  = $clog2(DW)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            shift_en,
    input  logic [DW-1:0]   din,
    input  logic [IW-1:0]   bit_sel,
    output logic [NTAP-1:0] slice
);

    typedef struct packed {
        logic [NTAP-1:0][DW-1:0] taps;
    } tap_s;

    tap_s r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (shift_en) begin
            for (int k = NTAP - 1; k > 0; k--) begin
                r_d.taps[k] = r_q.taps[k-1];
            end
            r_d.taps[0] = din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // bit k of the table address comes from tap k
    for (genvar k = 0; k < NTAP; k++) begin : g_slice
        assign slice[k] = r_q.taps[k][bit_sel];
    end

endmodule

// File: rtl/da_coef_rom.sv
module da_coef_rom #(
    parameter int NTAP = 8,
    parameter int CW   = 16,
    parameter int TW   = 19,
    parameter logic signed [CW-1:0] COEF [NTAP] = '{default: '0}
) (
    input  logic [NTAP-1:0]        addr,
    output logic signed [TW-1:0]   data
);

    localparam int DEPTH = 1 << NTAP;

    function automatic logic signed [TW-1:0] subset_sum(input int unsigned a);
        logic signed [TW-1:0] s;
        s = '0;
        for (int k = 0; k < NTAP; k++) begin
            if (((a >> k) & 1) != 0) s = s + TW'(COEF[k]);
        end
        return s;
    endfunction

    logic signed [TW-1:0] table_w [DEPTH];

    for (genvar a = 0; a < DEPTH; a++) begin : g_entry
        assign table_w[a] = subset_sum(a);
    end

    assign data = table_w[addr];

    always_comb begin
        if (addr == '0) begin
            p_zero_entry_r7: assert (data == '0);
        end
    end

endmodule

// File: rtl/da_acc_shift.sv
module da_acc_shift #(
    parameter int TW = 19,
    parameter int DW = 16,
    localparam int RW = TW + DW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 step,
    input  logic                 negate,
    input  logic signed [TW-1:0] lut,
    output logic signed [RW-1:0] sum_next
);

    typedef struct packed {
        logic signed [TW-1:0] hi;   // integer part after halving
        logic [DW-1:0]        lo;   // bits shifted out, kept exactly
    } acc_s;

    acc_s acc_d, acc_q;
    logic signed [TW:0] addend;
    logic signed [TW:0] total;

    always_comb begin
        acc_d  = acc_q;
        addend = negate ? -((TW+1)'(lut)) : (TW+1)'(lut);
        total  = (TW+1)'(acc_q.hi) + addend;
        if (clear) begin
            acc_d = '0;
        end else if (step) begin
            acc_d.hi = total[TW:1];
            acc_d.lo = {total[0], acc_q.lo[DW-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign sum_next = acc_d;

endmodule

// File: rtl/da_fir_core.sv
module da_fir_core
    import da_fir_pkg::*;
#(
    parameter int NTAP = 8,
    parameter int DW   = 16,
    parameter int CW   = 16,
    parameter logic signed [CW-1:0] COEF [NTAP] = '{
        16'sd1200, -16'sd3400, 16'sd5600, 16'sd32767,
        -16'sd32768, 16'sd700, -16'sd90, 16'sd12345},
    localparam int P  = grow_bits(NTAP),
    localparam int TW = CW + P,
    localparam int RW = DW + CW + P,
    localparam int IW = $clog2(DW)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [DW-1:0]        in_data,
    output logic                 in_ready,
    output logic                 result_valid,
    output logic signed [RW-1:0] result
);

    typedef struct packed {
        da_state_e            state;
        logic [IW-1:0]        bit_idx;
        logic                 out_valid;
        logic signed [RW-1:0] result;
    } ctrl_s;

    ctrl_s c_d, c_q;

    logic                 accept;
    logic                 running;
    logic                 last_bit;
    logic [NTAP-1:0]      slice;
    logic signed [TW-1:0] lut;
    logic signed [RW-1:0] sum_next;

    assign accept   = in_valid && (c_q.state == ST_IDLE);
    assign running  = (c_q.state == ST_RUN);
    assign last_bit = running && (c_q.bit_idx == IW'(DW - 1));

    always_comb begin
        c_d           = c_q;
        c_d.out_valid = 1'b0;
        if (accept) begin
            c_d.state   = ST_RUN;
            c_d.bit_idx = '0;
        end else if (running) begin
            c_d.bit_idx = c_q.bit_idx + 1'b1;
            if (last_bit) begin
                c_d.state     = ST_IDLE;
                c_d.bit_idx   = '0;
                c_d.out_valid = 1'b1;
                c_d.result    = sum_next;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q       <= '0;
            c_q.state <= ST_IDLE;
        end else begin
            c_q <= c_d;
        end
    end

    da_tap_line #(.NTAP(NTAP), .DW(DW)) u_taps (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (accept),
        .din      (in_data),
        .bit_sel  (c_q.bit_idx),
        .slice    (slice)
    );

    da_coef_rom #(.NTAP(NTAP), .CW(CW), .TW(TW), .COEF(COEF)) u_rom (
        .addr (slice),
        .data (lut)
    );

    da_acc_shift #(.TW(TW), .DW(DW)) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept),
        .step     (running),
        .negate   (last_bit),
        .lut      (lut),
        .sum_next (sum_next)
    );

    assign in_ready     = (c_q.state == ST_IDLE);
    assign result_valid = c_q.out_valid;
    assign result       = c_q.result;

    // checker-only latency counter
    int lat_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      lat_q <= 0;
        else if (in_valid && in_ready)   lat_q <= 1;
        else if (lat_q != 0 && lat_q <= DW) lat_q <= lat_q + 1;
    end

    p_accept_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    p_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);

    p_ready_at_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> in_ready);

    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> (lat_q == DW + 1));

    p_result_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !result_valid |-> $stable(result));

endmodule

// File: tb/da_fir_core_tb.sv
module da_fir_core_tb;

    localparam int NTAP = 8;
    localparam int DW   = 16;
    localparam int CW   = 16;
    localparam int RW   = DW + CW + 3;
    localparam logic signed [CW-1:0] TB_COEF [NTAP] = '{
        16'sd1200, -16'sd3400, 16'sd5600, 16'sd32767,
        -16'sd32768, 16'sd700, -16'sd90, 16'sd12345};

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic [DW-1:0]        in_data = '0;
    logic                 in_ready;
    logic                 result_valid;
    logic signed [RW-1:0] result;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    longint hist [NTAP];

    always #5 clk = ~clk;

    da_fir_core #(.NTAP(NTAP), .DW(DW), .CW(CW), .COEF(TB_COEF)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_data      (in_data),
        .in_ready     (in_ready),
        .result_valid (result_valid),
        .result       (result)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic longint model_push(input logic signed [DW-1:0] s);
        longint acc;
        for (int k = NTAP - 1; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = longint'(s);
        acc = 0;
        for (int k = 0; k < NTAP; k++) acc += longint'(TB_COEF[k]) * hist[k];
        return acc;
    endfunction

    // one sample through the block; junk is driven on in_valid while busy when set
    task automatic send(input logic signed [DW-1:0] s, input string tag, input bit junk);
        longint exp;
        @(negedge clk);
        check(in_ready == 1'b1, {tag, " R1 ready idle"}, longint'(in_ready), 1);
        in_valid = 1'b1;
        in_data  = s;
        exp = model_push(s);
        @(posedge clk);
        @(negedge clk);
        in_valid = junk;
        in_data  = 16'h7abc;
        for (int i = 1; i < DW; i++) begin
            @(posedge clk);
            #1;
            if (i == DW / 2)
                check(in_ready == 1'b0, {tag, " R1 busy"}, longint'(in_ready), 0);
            if (i == DW - 1)
                check(result_valid == 1'b0, {tag, " R2 early"}, longint'(result_valid), 0);
        end
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        check(result_valid == 1'b1, {tag, " R2 valid"}, longint'(result_valid), 1);
        check(longint'(result) == exp, {tag, " R3 value"}, longint'(result), exp);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        in_valid = 1'b0;
        for (int k = 0; k < NTAP; k++) hist[k] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(result_valid == 1'b0, "R4 reset valid", longint'(result_valid), 0);
        check(in_ready == 1'b1, "R4 reset ready", longint'(in_ready), 1);
    endtask

    task automatic t_impulse();
        send(16'sd1, "R7 impulse0", 1'b0);
        for (int k = 1; k < NTAP + 1; k++) send(16'sd0, "R7 impulse", 1'b0);
    endtask

    task automatic t_neg_impulse();
        send(-16'sd1, "R8 neg impulse0", 1'b0);
        for (int k = 1; k < NTAP + 1; k++) send(16'sd0, "R8 neg impulse", 1'b0);
    endtask

    task automatic t_pulse_width();
        send(16'sd777, "R2 pulse", 1'b0);
        @(posedge clk);
        #1;
        check(result_valid == 1'b0, "R2 one cycle", longint'(result_valid), 0);
    endtask

    task automatic t_busy_ignore();
        for (int i = 0; i < 12; i++) send(16'(i * 911 - 4000), "R5 busy junk", 1'b1);
    endtask

    task automatic t_random();
        for (int i = 0; i < 60; i++) send(16'($urandom()), "R3 random", 1'b0);
    endtask

    task automatic t_extreme();
        for (int i = 0; i < NTAP + 2; i++) send(-16'sd32768, "R6 min", 1'b0);
        for (int i = 0; i < NTAP + 2; i++) send(16'sd32767, "R6 max", 1'b0);
        for (int i = 0; i < 2 * NTAP; i++)
            send((i % 2) ? 16'sd32767 : -16'sd32768, "R6 alt", 1'b0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        t_reset();
        t_impulse();
        t_neg_impulse();
        t_pulse_width();
        t_busy_ignore();
        t_random();
        t_extreme();
        t_reset();
        send(16'sd3, "R4 history cleared", 1'b0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule